// File: doc/BRIEF.md
# Mixed-Radix Ling Prefix Adder

A purely combinational binary adder of configurable width. It adds two operands and a one-bit carry-in, and it produces a sum of the same width plus a carry-out. Internally it does not form ordinary carries. It forms Ling pseudo-carries, H_i = g_i | c_{i-1}, where g_i = a_i & b_i. The pseudo-carries can be combined over indices of one parity only. Odd and even bit positions therefore get two independent parallel-prefix trees, and each tree spans half of the operand width.

Each tree is built from levels of group cells. At every level, elements are gathered into groups of `radix` sub-blocks, and each element absorbs the end terms of all lower sub-blocks in its group. A cell therefore takes 2, 3 or 4 group inputs. A packed parameter gives the radix of each level, one nibble per level with the lowest level in the lowest nibble. This lets one adder mix radices and build a wide adder hierarchically. The default configuration is 64 bits. Each 16-bit slice is formed by radix-4 and radix-2 levels, and the four slices are then joined by a radix-4 level, which gives three levels in total. After the trees, the true carry is recovered as c_i = t_i & H_i with t_i = a_i | b_i, and each sum bit is formed as (a_i ^ b_i) ^ c_{i-1}.

Top module: `ling_prefix_adder`

## Requirements
- R1: For every input combination and every legal radix configuration (the product of the level radices is at least WIDTH/2), {carry_o, sum_o} equals a_i + b_i + carry_i.
- R2: With both operands zero and carry_i = 1, sum_o is 1 and carry_o is 0.
- R3: With a_i all ones, the carry travels the full width: adding b_i = 0 with carry_i = 1, or adding b_i = 1 with carry_i = 0, gives sum_o = 0 and carry_o = 1.
- R4: The carry into each bit position, which is visible at the ports as sum_o[i] ^ a_i[i] ^ b_i[i], equals the arithmetic carry into that position. Internally the recovered carry t_i & H_i equals the arithmetic carry out of bit i.
- R5: The internal pseudo-carry of bit i equals g_i | c_{i-1}, where c_{-1} = carry_i. An isolated generate (a_i = b_i = 2^k, carry_i = 0) yields exactly sum_o = 2^(k+1), or carry_o = 1 alone when k = WIDTH-1.
- R6: Adders of the same width that use different radix configurations (radix 2 then 2, radix 3 then 2, a single radix-4 level) give identical outputs for identical inputs.
- R7: Alternating-bit operands, which load the odd and even trees differently, add correctly. 0x55..5 + 0xAA..A gives all ones with carry_o = 0 when carry_i = 0, and gives zero with carry_o = 1 when carry_i = 1. The patterns 0xAA..A + 0xAA..A and 0x55..5 + 0x55..5 + 1 match the arithmetic sum.
- R8: carry_o is 1 exactly when a_i + b_i + carry_i is at least 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits |
| carry_o | output | 1 | Carry out of the most significant bit |

## Verification
The carry-in injection and a full-length propagate chain can act in the same evaluation. In that case the carry-in has to enter the odd tree through the special term at bit 1 and the even tree through bit 0, and it must cross every radix level of both trees. All-ones operands with carry_i set, and alternating patterns with carry_i set, provoke exactly this overlap. Every result is judged against an arithmetic sum computed in the bench at a width one bit larger. Exhaustive sweeps of three differently configured 8-bit adders, plus corner and random vectors on 12-, 16- and 64-bit adders, check that the outcome does not depend on the radix choice.

// File: rtl/ling_prefix_adder.sv
module ling_prefix_adder #(
  parameter int          WIDTH      = 64,
  parameter int          LEVELS     = 3,
  parameter logic [31:0] RADIX_CODE = 32'h0000_0424
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int HALF = WIDTH / 2;

  function automatic int radix_at(input int lvl);
    int r;
    r = int'(RADIX_CODE[4*lvl +: 4]);
    return (r < 2) ? 1 : r;
  endfunction

  logic [WIDTH-1:0] gen, trn, hlf, pseudo, rec;
  logic [WIDTH:0]   ge;
  logic [WIDTH+1:0] te;

  assign gen = a_i & b_i;
  assign trn = a_i | b_i;
  assign hlf = a_i ^ b_i;
  assign ge  = {gen, carry_i};
  assign te  = {trn, 2'b00};

  for (genvar p = 0; p < 2; p++) begin : g_tree
    logic [HALF-1:0] hv [LEVELS+1];
    logic [HALF-1:0] qv [LEVELS+1];

    always_comb begin
      int  span, rdx, blk, base, sub, idx;
      logic hacc, qacc;
      span = 1; rdx = 1; blk = 1; base = 0; sub = 0; idx = 0;
      hacc = 1'b0; qacc = 1'b0;
      for (int k = 0; k < HALF; k++) begin
        hv[0][k] = gen[2*k+p] | ge[2*k+p] | ((2*k+p == 1) & trn[0] & carry_i);
        qv[0][k] = te[2*k+p+1] & te[2*k+p];
      end
      for (int l = 0; l < LEVELS; l++) begin
        rdx = radix_at(l);
        blk = span * rdx;
        for (int k = 0; k < HALF; k++) begin
          base = (k / blk) * blk;
          sub  = (k - base) / span;
          hacc = hv[l][k];
          qacc = qv[l][k];
          for (int m = sub - 1; m >= 0; m--) begin
            idx  = base + m * span + span - 1;
            hacc = hacc | (qacc & hv[l][idx]);
            qacc = qacc & qv[l][idx];
          end
          hv[l+1][k] = hacc;
          qv[l+1][k] = qacc;
        end
        span = blk;
      end
    end

    for (genvar k = 0; k < HALF; k++) begin : g_out
      assign pseudo[2*k+p] = hv[LEVELS][k];
    end
  end

  assign rec     = trn & pseudo;
  assign sum_o   = hlf ^ {rec[WIDTH-2:0], carry_i};
  assign carry_o = rec[WIDTH-1];

  logic [WIDTH:0] ref_total, ref_carry;
  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i};
    ref_carry = ref_total ^ {1'b0, a_i} ^ {1'b0, b_i};
    AST_SUM_EXACT: assert ({carry_o, sum_o} == ref_total) else $error("sum differs from arithmetic total"); // R1
    AST_CARRY_RECOVER: assert (rec == ref_carry[WIDTH:1]) else $error("recovered carry wrong"); // R4
    AST_PSEUDO_DEF: assert (pseudo == (gen | ref_carry[WIDTH-1:0])) else $error("pseudo-carry wrong"); // R5
    AST_COUT_RANGE: assert (carry_o == (ref_total > {1'b0, {WIDTH{1'b1}}})) else $error("carry-out wrong"); // R8
  end
endmodule

// File: tb/tb_ling_prefix_adder.sv
module tb_ling_prefix_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  logic [63:0] a64 = '0, b64 = '0, s64;
  logic        c64 = 1'b0, co64;
  logic [11:0] a12 = '0, b12 = '0, s12;
  logic        c12 = 1'b0, co12;
  logic [15:0] a16 = '0, b16 = '0, s16;
  logic        c16 = 1'b0, co16;
  logic [7:0]  a8 = '0, b8 = '0, s8a, s8b, s8c;
  logic        c8 = 1'b0, co8a, co8b, co8c;

  ling_prefix_adder dut (.a_i(a64), .b_i(b64), .carry_i(c64), .sum_o(s64), .carry_o(co64));
  ling_prefix_adder #(.WIDTH(12), .LEVELS(2), .RADIX_CODE(32'h23)) u12 (
    .a_i(a12), .b_i(b12), .carry_i(c12), .sum_o(s12), .carry_o(co12));
  ling_prefix_adder #(.WIDTH(16), .LEVELS(2), .RADIX_CODE(32'h33)) u16 (
    .a_i(a16), .b_i(b16), .carry_i(c16), .sum_o(s16), .carry_o(co16));
  ling_prefix_adder #(.WIDTH(8), .LEVELS(2), .RADIX_CODE(32'h22)) u8a (
    .a_i(a8), .b_i(b8), .carry_i(c8), .sum_o(s8a), .carry_o(co8a));
  ling_prefix_adder #(.WIDTH(8), .LEVELS(2), .RADIX_CODE(32'h23)) u8b (
    .a_i(a8), .b_i(b8), .carry_i(c8), .sum_o(s8b), .carry_o(co8b));
  ling_prefix_adder #(.WIDTH(8), .LEVELS(1), .RADIX_CODE(32'h4)) u8c (
    .a_i(a8), .b_i(b8), .carry_i(c8), .sum_o(s8c), .carry_o(co8c));

  task automatic check(input string req, input logic [64:0] got, input logic [64:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic apply_wide(input logic [63:0] a, input logic [63:0] b, input logic c, input string tag);
    logic [64:0] e64;
    logic [12:0] e12;
    logic [16:0] e16;
    @(posedge clk); #1;
    a64 = a; b64 = b; c64 = c;
    a12 = a[11:0]; b12 = b[11:0]; c12 = c;
    a16 = a[15:0]; b16 = b[15:0]; c16 = c;
    #2;
    e64 = {1'b0, a} + {1'b0, b} + {64'd0, c};
    e12 = {1'b0, a[11:0]} + {1'b0, b[11:0]} + {12'd0, c};
    e16 = {1'b0, a[15:0]} + {1'b0, b[15:0]} + {16'd0, c};
    check({tag, " R1 64-bit"}, {co64, s64}, e64);
    check({tag, " R1 12-bit"}, 65'({co12, s12}), 65'(e12));
    check({tag, " R1 16-bit"}, 65'({co16, s16}), 65'(e16));
    check({tag, " R4 carry vector"}, 65'(s64 ^ a ^ b), 65'(e64[63:0] ^ a ^ b));
    check({tag, " R8 carry-out"}, 65'(co64), 65'(e64[64]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [8:0]  e9;
    logic [64:0] one_hot_sum;
    #3;
    check("R1 idle zero output", {co64, s64}, 65'd0);

    apply_wide(64'd0, 64'd0, 1'b1, "R2");
    check("R2 sum one", {co64, s64}, 65'd1);
    apply_wide('1, 64'd0, 1'b1, "R3");
    check("R3 wrap", {co64, s64}, {1'b1, 64'd0});
    apply_wide('1, 64'd1, 1'b0, "R3");
    check("R3 wrap no cin", {co64, s64}, {1'b1, 64'd0});

    apply_wide({16{4'h5}}, {16{4'hA}}, 1'b0, "R7");
    check("R7 alt no cin", {co64, s64}, {1'b0, {64{1'b1}}});
    apply_wide({16{4'h5}}, {16{4'hA}}, 1'b1, "R7");
    check("R7 alt with cin", {co64, s64}, {1'b1, 64'd0});
    apply_wide({16{4'hA}}, {16{4'hA}}, 1'b0, "R7");
    apply_wide({16{4'h5}}, {16{4'h5}}, 1'b1, "R7");

    for (int k = 0; k < 64; k++) begin
      apply_wide(64'd1 << k, 64'd1 << k, 1'b0, "R5");
      one_hot_sum = 65'd1 << (k + 1);
      check("R5 isolated generate", {co64, s64}, one_hot_sum);
    end

    for (int n = 0; n < 3000; n++) begin
      apply_wide({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
    end

    for (int v = 0; v < (1 << 17); v++) begin
      @(posedge clk); #1;
      a8 = v[7:0]; b8 = v[15:8]; c8 = v[16];
      #2;
      e9 = {1'b0, a8} + {1'b0, b8} + {8'd0, c8};
      check("R1 8-bit radix 2,2", 65'({co8a, s8a}), 65'(e9));
      check("R1 8-bit radix 3,2", 65'({co8b, s8b}), 65'(e9));
      check("R1 8-bit radix 4", 65'({co8c, s8c}), 65'(e9));
      check("R8 8-bit carry-out", 65'(co8b), 65'(e9[8]));
      check("R6 radix independence 3,2", 65'({co8b, s8b}), 65'({co8a, s8a}));
      check("R6 radix independence 4", 65'({co8c, s8c}), 65'({co8a, s8a}));
    end

    report();
  end
endmodule